// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block sits between a frame source and the transmit path of an Ethernet MAC. It accepts the bytes of one frame at a time on a byte-wide valid/ready stream and passes them to a registered byte-wide output. On the way it can write the locally held station address over the source-address field, and it can append a CRC-32 frame check sequence after the last payload byte.

A two-bit loopback mode picks where the finished frame goes. Mode 0 sends it to the transmit output. Mode 1 sends it to a separate loopback output. Modes 2 and 3 consume the frame and emit nothing.

All configuration inputs are taken when the first byte of a frame is accepted. Each frame is therefore assembled with one consistent set of options, and the configuration may change while an earlier frame is still draining.

Top module: `eth_tx_frame_asm`

## Requirements
- R1: After reset, `tx_valid`, `lb_valid` and `cfg_err` are 0, and `in_ready` is 1.
- R2: When `cfg_keep_src` is 0, output bytes at positions 6 to 11 of the frame (first byte is position 0) are replaced by `station_addr`, with bits 47:40 at position 6 and bits 7:0 at position 11. When `cfg_keep_src` is 1, every byte passes unchanged.
- R3: Four check bytes are appended only when `cfg_skip_fcs` is 0, `cmd_skip_fcs` is 0 and `cfg_lb_mode` is 0. In every other case the frame ends with its last payload byte.
- R4: The check value is the reflected CRC-32 (polynomial 0xEDB88320) over all emitted frame bytes, including any substituted address. The register starts at all ones and the result is complemented. Bits 31:24 are emitted first and bits 7:0 last, and `tx_last` is set on the final check byte.
- R5: With `cfg_lb_mode` 0 the frame appears on the tx output and with 1 on the lb output. With 2 or 3 the input is consumed and neither output shows a beat.
- R6: `cfg_fcs16` set to 1 sets `cfg_err` one clock later, and `cfg_err` clears one clock after `cfg_fcs16` returns to 0. The check sequence stays CRC-32.
- R7: Frames of up to 1540 output bytes, check bytes included, are carried without loss.
- R8: An output beat holds its data and last flag while its ready is low. The check bytes follow the final payload byte with no idle cycle whenever the sink accepts each byte. No input is accepted while the check bytes are pending.
- R9: A single input beat with `in_empty` and `in_last` both 1, at the start of a frame, is consumed and produces no output and no check bytes.
- R10: The configuration inputs, `cmd_skip_fcs` and `station_addr` are sampled when the first byte of a frame is accepted. Changing them later in the same frame has no effect on that frame.
- R11: A byte accepted on a clock edge is presented on its output from that same edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_keep_src | input | 1 | 1: leave the source-address field as received |
| cfg_skip_fcs | input | 1 | 1: never append check bytes |
| cfg_fcs16 | input | 1 | Request for 16-bit check, unsupported; raises cfg_err |
| cfg_lb_mode | input | 2 | 0 transmit, 1 loopback, 2/3 discard |
| cmd_skip_fcs | input | 1 | Per-frame command bit: 1 suppresses check bytes |
| station_addr | input | 48 | Station address; bits 47:40 go out first |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Last byte of the frame |
| in_empty | input | 1 | With in_last on the first beat: empty frame |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Last transmit byte of the frame |
| lb_valid | output | 1 | Loopback beat valid |
| lb_ready | input | 1 | Loopback sink ready |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Last loopback byte of the frame |
| cfg_err | output | 1 | Unsupported check width requested |

## Verification
Each accepted input byte is due on its output one edge after acceptance. The first check byte is due one edge after the last payload byte leaves, and `cfg_err` one edge after its request changes. The bench drives every input just after the falling edge and reads the outputs and ready signals two time units later. At that point, each value loaded by the previous rising edge is settled.

A behavioural model builds queues of expected beats for both outputs when each frame starts. On every clock it pops one entry per observed handshake and compares it. Any beat that arrives while its queue is empty counts as a failure. After each check byte that is not the last, the model requires `tx_valid` in the very next cycle.

// File: rtl/eth_txa_pkg.sv
package eth_txa_pkg;

  localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] FCS_SEED      = 32'hFFFFFFFF;

  // destination selected by the two-bit loopback field
  typedef enum logic [1:0] {
    LB_OFF    = 2'd0,
    LB_WRAP   = 2'd1,
    LB_DROP_A = 2'd2,
    LB_DROP_B = 2'd3
  } lb_mode_e;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_FCS  = 1'b1
  } phase_e;

  // one byte of reflected CRC-32, low bit first
  function automatic logic [31:0] fcs_step(input logic [31:0] cur, input logic [7:0] b);
    logic [31:0] r;
    r = cur ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ FCS_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_txa_crc32.sv
module eth_txa_crc32
  import eth_txa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);

  logic [31:0] acc;
  logic [31:0] base;

  assign base = restart ? FCS_SEED : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= FCS_SEED;
    end else if (upd) begin
      acc <= fcs_step(base, din);
    end else if (restart) begin
      acc <= FCS_SEED;
    end
  end

  assign fcs = ~acc;

endmodule

// File: rtl/eth_txa_src_mux.sv
module eth_txa_src_mux #(
  parameter int CNT_W      = 11,
  parameter int BYTE_W     = 8,
  parameter int ADDR_OFS   = 6,
  parameter int ADDR_BYTES = 6
) (
  input  logic [CNT_W-1:0]             pos,
  input  logic                         enable,
  input  logic [BYTE_W-1:0]            din,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station,
  output logic [BYTE_W-1:0]            dout
);

  logic [ADDR_BYTES-1:0] hit;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_hit
    assign hit[g] = enable && (pos == CNT_W'(ADDR_OFS + g));
  end

  always_comb begin
    dout = din;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (hit[k]) dout = station[(ADDR_BYTES-1-k)*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/eth_txa_out_stage.sv
module eth_txa_out_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              ld_last,
  input  logic              ld_to_lb,
  output logic              free,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic              lb_valid,
  input  logic              lb_ready,
  output logic [BYTE_W-1:0] lb_data,
  output logic              lb_last
);

  logic              tx_v, lb_v, l_q;
  logic [BYTE_W-1:0] d_q;

  assign free = (!tx_v || tx_ready) && (!lb_v || lb_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_v <= 1'b0;
      lb_v <= 1'b0;
      d_q  <= '0;
      l_q  <= 1'b0;
    end else if (load) begin
      tx_v <= !ld_to_lb;
      lb_v <= ld_to_lb;
      d_q  <= ld_data;
      l_q  <= ld_last;
    end else begin
      if (tx_ready) tx_v <= 1'b0;
      if (lb_ready) lb_v <= 1'b0;
    end
  end

  assign tx_valid = tx_v;
  assign tx_data  = d_q;
  assign tx_last  = l_q;
  assign lb_valid = lb_v;
  assign lb_data  = d_q;
  assign lb_last  = l_q;

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R8
  lb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_data) && $stable(lb_last)));

endmodule

// File: rtl/eth_tx_frame_asm.sv
module eth_tx_frame_asm
  import eth_txa_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAX_FRAME  = 1540,
  parameter int ADDR_OFS   = 6,
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_keep_src,
  input  logic                         cfg_skip_fcs,
  input  logic                         cfg_fcs16,
  input  logic [1:0]                   cfg_lb_mode,
  input  logic                         cmd_skip_fcs,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [BYTE_W-1:0]            in_data,
  input  logic                         in_last,
  input  logic                         in_empty,
  output logic                         tx_valid,
  input  logic                         tx_ready,
  output logic [BYTE_W-1:0]            tx_data,
  output logic                         tx_last,
  output logic                         lb_valid,
  input  logic                         lb_ready,
  output logic [BYTE_W-1:0]            lb_data,
  output logic                         lb_last,
  output logic                         cfg_err
);

  localparam int CNT_W     = $clog2(MAX_FRAME + 1);
  localparam int FCS_BYTES = 32 / BYTE_W;
  localparam int FIDX_W    = $clog2(FCS_BYTES);
  localparam int SADDR_W   = ADDR_BYTES * BYTE_W;

  phase_e               phase;
  logic [CNT_W-1:0]     pos;
  logic [FIDX_W-1:0]    fcs_idx;
  logic                 l_keep, l_fcs_en;
  logic [1:0]           l_mode;
  logic [SADDR_W-1:0]   l_sta;

  logic                 first, live_fcs_en;
  logic                 e_keep, e_fcs_en, e_drop;
  logic [1:0]           e_mode;
  logic [SADDR_W-1:0]   e_sta;
  logic                 null_beat, acc, take, st_free;
  logic [BYTE_W-1:0]    mod_byte, fcs_byte, ld_data;
  logic                 load, ld_last, ld_to_lb;
  logic [31:0]          fcs;

  assign first       = (pos == '0);
  assign live_fcs_en = !cfg_skip_fcs && !cmd_skip_fcs && (cfg_lb_mode == LB_OFF);
  assign e_keep      = first ? cfg_keep_src : l_keep;
  assign e_mode      = first ? cfg_lb_mode  : l_mode;
  assign e_fcs_en    = first ? live_fcs_en  : l_fcs_en;
  assign e_sta       = first ? station_addr : l_sta;
  assign e_drop      = e_mode[1];

  assign null_beat = first && in_empty && in_last;
  assign in_ready  = (phase == PH_DATA) && (e_drop || null_beat || st_free);
  assign acc       = in_valid && in_ready;
  assign take      = acc && !null_beat;

  eth_txa_src_mux #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_OFS(ADDR_OFS), .ADDR_BYTES(ADDR_BYTES)
  ) u_src (
    .pos(pos), .enable(!e_keep), .din(in_data), .station(e_sta), .dout(mod_byte)
  );

  eth_txa_crc32 u_crc (
    .clk(clk), .rst(rst), .restart(take && first), .upd(take),
    .din(mod_byte), .fcs(fcs)
  );

  assign fcs_byte = BYTE_W'(fcs >> (BYTE_W * (FCS_BYTES - 1 - int'(fcs_idx))));

  always_comb begin
    if (phase == PH_FCS) begin
      load     = st_free;
      ld_data  = fcs_byte;
      ld_last  = (fcs_idx == FIDX_W'(FCS_BYTES - 1));
      ld_to_lb = 1'b0;
    end else begin
      load     = take && !e_drop;
      ld_data  = mod_byte;
      ld_last  = in_last && !e_fcs_en;
      ld_to_lb = (e_mode == LB_WRAP);
    end
  end

  eth_txa_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .ld_data(ld_data), .ld_last(ld_last),
    .ld_to_lb(ld_to_lb), .free(st_free),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .lb_valid(lb_valid), .lb_ready(lb_ready), .lb_data(lb_data), .lb_last(lb_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_DATA;
      pos      <= '0;
      fcs_idx  <= '0;
      l_keep   <= 1'b0;
      l_fcs_en <= 1'b0;
      l_mode   <= 2'd0;
      l_sta    <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_fcs16;
      if (take) begin
        if (first) begin
          l_keep   <= cfg_keep_src;
          l_mode   <= cfg_lb_mode;
          l_fcs_en <= live_fcs_en;
          l_sta    <= station_addr;
        end
        pos <= in_last ? '0 : pos + CNT_W'(1);
        if (in_last && e_fcs_en) begin
          phase   <= PH_FCS;
          fcs_idx <= '0;
        end
      end
      if (phase == PH_FCS && st_free) begin
        fcs_idx <= fcs_idx + FIDX_W'(1);
        if (fcs_idx == FIDX_W'(FCS_BYTES - 1)) phase <= PH_DATA;
      end
    end
  end

  // output beat counter used by the length check
  logic [CNT_W-1:0] out_cnt;
  logic             hs, hs_last;
  assign hs      = (tx_valid && tx_ready) || (lb_valid && lb_ready);
  assign hs_last = (tx_valid && tx_ready) ? tx_last : lb_last;

  always_ff @(posedge clk) begin
    if (rst) out_cnt <= '0;
    else if (hs) out_cnt <= hs_last ? '0 : out_cnt + CNT_W'(1);
  end

  // R7
  frm_len_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && !hs_last) |-> (out_cnt < CNT_W'(MAX_FRAME - 1)));

  // R8
  fcs_nogap_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FCS && tx_valid && tx_ready && !tx_last) |=> tx_valid);

  // R9
  null_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && null_beat && !tx_valid && !lb_valid) |=> (!tx_valid && !lb_valid));

endmodule

// File: tb/tb_eth_tx_frame_asm.sv
module tb_eth_tx_frame_asm;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_keep_src = 1'b0, cfg_skip_fcs = 1'b0, cfg_fcs16 = 1'b0, cmd_skip_fcs = 1'b0;
  logic [1:0]  cfg_lb_mode = 2'd0;
  logic [47:0] station_addr = 48'h02A1B2C3D4E5;
  logic        in_valid = 1'b0, in_last = 1'b0, in_empty = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        tx_valid, tx_last, lb_valid, lb_last, cfg_err;
  logic [7:0]  tx_data, lb_data;
  logic        tx_ready = 1'b1, lb_ready = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_frame_asm dut (
    .clk(clk), .rst(rst), .cfg_keep_src(cfg_keep_src), .cfg_skip_fcs(cfg_skip_fcs),
    .cfg_fcs16(cfg_fcs16), .cfg_lb_mode(cfg_lb_mode), .cmd_skip_fcs(cmd_skip_fcs),
    .station_addr(station_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_empty(in_empty),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .lb_valid(lb_valid), .lb_ready(lb_ready), .lb_data(lb_data), .lb_last(lb_last),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sink ready patterns: 0 always, 1 pseudo-random, 2 never
  int          tx_rmode = 0, lb_rmode = 0;
  logic [15:0] lf = 16'hACE1;
  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    tx_ready = (tx_rmode == 0) ? 1'b1 : (tx_rmode == 1) ? lf[0] : 1'b0;
    lb_ready = (lb_rmode == 0) ? 1'b1 : (lb_rmode == 1) ? lf[3] : 1'b0;
  end

  // behavioural model: expected beats {next_is_fcs, last, data}
  logic [9:0] txq[$];
  logic [9:0] lbq[$];
  logic [7:0] frame [0:1599];
  bit         gap_watch = 1'b0;

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (gap_watch) chk(tx_valid == 1'b1, "R8 fcs byte gap", {31'h0, tx_valid}, 32'h1);
      gap_watch = 1'b0;
      if (tx_valid && tx_ready) begin
        if (txq.size() == 0) chk(1'b0, "R5 unexpected tx beat", {23'h0, tx_last, tx_data}, 32'h0);
        else begin
          logic [9:0] e;
          e = txq.pop_front();
          chk({tx_last, tx_data} == e[8:0], "R2/R3/R4 tx beat", {23'h0, tx_last, tx_data}, {23'h0, e[8:0]});
          gap_watch = e[9];
        end
      end
      if (lb_valid && lb_ready) begin
        if (lbq.size() == 0) chk(1'b0, "R5 unexpected lb beat", {23'h0, lb_last, lb_data}, 32'h0);
        else begin
          logic [9:0] e;
          e = lbq.pop_front();
          chk({lb_last, lb_data} == e[8:0], "R5 lb beat", {23'h0, lb_last, lb_data}, {23'h0, e[8:0]});
        end
      end
    end
  end

  function automatic logic [31:0] ref_crc(input logic [7:0] bytes[], input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ bytes[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) frame[i] = 8'(seed * 7 + i * 13 + (i >> 3));
  endtask

  task automatic push_expected(input int len);
    logic [7:0] m[];
    logic       fen;
    logic [31:0] c;
    m = new[len];
    for (int i = 0; i < len; i++) begin
      m[i] = frame[i];
      if (!cfg_keep_src && i >= 6 && i < 12) m[i] = station_addr[47 - 8*(i-6) -: 8];
    end
    fen = !cfg_skip_fcs && !cmd_skip_fcs && (cfg_lb_mode == 2'd0);
    c = ref_crc(m, len);
    for (int i = 0; i < len; i++) begin
      logic [9:0] e;
      e = {fen && (i == len-1), (i == len-1) && !fen, m[i]};
      if (cfg_lb_mode == 2'd0) txq.push_back(e);
      else if (cfg_lb_mode == 2'd1) lbq.push_back(e);
    end
    if (fen) begin
      for (int k = 0; k < 4; k++) txq.push_back({k < 3, k == 3, c[31 - 8*k -: 8]});
    end
  endtask

  // drives one frame; with chg set, options flip after the first byte
  task automatic send_frame(input int len, input bit chg);
    push_expected(len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (chg && i == 1) begin
        cfg_keep_src = ~cfg_keep_src;
        cfg_skip_fcs = ~cfg_skip_fcs;
        cfg_lb_mode  = 2'd1;
        station_addr = ~station_addr;
      end
      in_valid = 1'b1;
      in_data  = frame[i];
      in_last  = (i == len - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain(input string req);
    while (txq.size() != 0 || lbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    chk(!tx_valid && !lb_valid, req, {30'h0, tx_valid, lb_valid}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] anchor[];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk(!tx_valid && !lb_valid, "R1 outputs idle", {30'h0, tx_valid, lb_valid}, 32'h0);
    chk(!cfg_err, "R1 cfg_err low", {31'h0, cfg_err}, 32'h0);
    chk(in_ready, "R1 in_ready high", {31'h0, in_ready}, 32'h1);

    // R4 model anchor
    anchor = new[9];
    for (int i = 0; i < 9; i++) anchor[i] = 8'h31 + 8'(i);
    chk(ref_crc(anchor, 9) == 32'hCBF43926, "R4 crc anchor", ref_crc(anchor, 9), 32'hCBF43926);

    // R2 R3 R4: substitution and check bytes on tx
    fill(64, 1); send_frame(64, 1'b0); drain("R4 frame done");

    // R2 keep source, R3 global skip
    cfg_keep_src = 1'b1; cfg_skip_fcs = 1'b1;
    fill(20, 2); send_frame(20, 1'b0); drain("R3 no fcs done");
    cfg_keep_src = 1'b0; cfg_skip_fcs = 1'b0;

    // R3 per-command skip, short frame cut inside address field
    cmd_skip_fcs = 1'b1;
    fill(8, 3); send_frame(8, 1'b0); drain("R3 cmd skip done");
    cmd_skip_fcs = 1'b0;

    // R5 loopback with random ready, no check bytes
    cfg_lb_mode = 2'd1; lb_rmode = 1;
    fill(40, 4); send_frame(40, 1'b0); drain("R5 loopback done");
    lb_rmode = 0;

    // R5 discard modes
    cfg_lb_mode = 2'd2; fill(30, 5); send_frame(30, 1'b0); drain("R5 mode 2 drop");
    cfg_lb_mode = 2'd3; fill(17, 6); send_frame(17, 1'b0); drain("R5 mode 3 drop");
    cfg_lb_mode = 2'd0;

    // R9 empty frame
    @(negedge clk);
    in_valid = 1'b1; in_empty = 1'b1; in_last = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_empty = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(!tx_valid && !lb_valid, "R9 empty frame silent", {30'h0, tx_valid, lb_valid}, 32'h0);
    fill(16, 7); send_frame(16, 1'b0); drain("R9 next frame intact");

    // R10 options changed after first byte
    fill(24, 8); send_frame(24, 1'b1); drain("R10 held config");
    cfg_keep_src = 1'b0; cfg_skip_fcs = 1'b0; cfg_lb_mode = 2'd0; station_addr = 48'h02A1B2C3D4E5;

    // R8 random back-pressure with check bytes
    tx_rmode = 1;
    fill(50, 9); send_frame(50, 1'b0);
    fill(13, 10); send_frame(13, 1'b0); drain("R8 backpressure done");
    tx_rmode = 0;

    // R7 longest frame
    fill(1536, 11); send_frame(1536, 1'b0); drain("R7 max frame done");

    // R6 unsupported check width
    @(negedge clk); cfg_fcs16 = 1'b1;
    @(negedge clk); #2;
    chk(cfg_err, "R6 cfg_err set", {31'h0, cfg_err}, 32'h1);
    fill(33, 12); send_frame(33, 1'b0); drain("R6 crc32 kept");
    @(negedge clk); cfg_fcs16 = 1'b0;
    @(negedge clk); #2;
    chk(!cfg_err, "R6 cfg_err clear", {31'h0, cfg_err}, 32'h0);

    // R11 one-edge latency, R8 hold under stall
    cfg_lb_mode = 2'd1; lb_rmode = 2;
    repeat (2) @(negedge clk);
    frame[0] = 8'h5C;
    send_frame(1, 1'b0);
    #2;
    chk(lb_valid && lb_last && lb_data == 8'h5C, "R11 byte presented", {23'h0, lb_last, lb_data}, 32'h15C);
    repeat (3) @(negedge clk);
    #2;
    chk(lb_valid && lb_data == 8'h5C, "R8 held while stalled", {23'h0, lb_valid, lb_data}, 32'h15C);
    lb_rmode = 0;
    drain("R11 drained");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule